// File: doc/BRIEF.md
# Cartridge Bank Controller with Clock Capture

This block sits between a CPU bus and a cartridge's memories. CPU writes to the lower half of the 16-bit space (0x0000 to 0x7FFF) never reach ROM. Instead they land in four control registers: the external RAM enable, the ROM bank number, the RAM bank or clock selector, and the clock capture control. From these registers the block forms a physical ROM address for every CPU address. The fixed area 0x0000 to 0x3FFF always maps to bank 0. The switchable area 0x4000 to 0x7FFF maps to the selected bank. For the 8 KiB window at 0xA000 to 0xBFFF the block forms a physical RAM address and a RAM write strobe.

The RAM selector has a second role. A selector value from 8 to 12 replaces the RAM in the window with one of five captured clock bytes. Clock counting happens outside the block and arrives as live byte inputs. The captured copy is taken on a rising step of bit 0 in the capture control register. A write to a mapped clock byte updates the captured copy. It also raises a strobe so the outside counter can take the same value.

When the window is disabled, or when it shows a clock byte, the block supplies the read data itself through an override output. When the window shows RAM, the data comes from external storage.

The capture control is a two-state machine. `LATCH_LOW` means the last written bit 0 was clear. `LATCH_HIGH` means it was set. The transitions are:
- CAPTURE: from `LATCH_LOW` to `LATCH_HIGH` on a write with bit 0 set. This also fires the snapshot.
- REARM: from `LATCH_HIGH` to `LATCH_LOW` on a write with bit 0 clear.
- Any other write leaves the state unchanged.

For each access the window resolves to one of four modes:
- `WIN_NONE`: the address is outside the window.
- `WIN_OFF`: the window is disabled or no RAM is fitted.
- `WIN_RAM`: the window shows RAM.
- `WIN_CLOCK`: the window shows a clock byte.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the RAM window is disabled, the ROM bank register holds 0, the selector holds 0, the capture machine is in LATCH_LOW and all five captured bytes are 0x00.
- R2: A write to 0x0000–0x1FFF enables the window when wdata[3:0] equals 0xA, whatever the upper nibble. Any other low nibble disables it.
- R3: rom_addr equals cpu_addr[13:0] when cpu_addr[15:14] is 00. When cpu_addr[15:14] is 01, rom_addr equals bank×0x4000 + cpu_addr[13:0], truncated to ROM_ADDR_W bits. The bank register takes all 8 bits of a write to 0x2000–0x3FFF.
- R4: A bank register value of 0 maps the switchable area to bank 1.
- R5: A write to 0x4000–0x5FFF stores all 8 bits in the selector. ram_addr equals selector×0x2000 + cpu_addr[12:0], truncated to RAM_ADDR_W bits. A selector outside 8..12 shows RAM, with ovr_valid low and ram_we equal to cpu_wr inside the window.
- R6: With the window disabled, or with HAS_RAM = 0, a window access drives ovr_valid = 1 and ovr_data = 0xFF. A write there raises neither ram_we nor clk_wr. Outside the window ovr_valid is 0.
- R7: A selector value s in 8..12 shows captured byte s−8 through ovr_data with ovr_valid = 1. Byte 4 reads with bits 1 to 5 forced to 1.
- R8: A write to 0x6000–0x7FFF with bit 0 set copies all five live bytes (live_time byte i = clock byte i) into the captured set, but only if the previous such write had bit 0 clear. Repeated writes with bit 0 set copy nothing.
- R9: A window write while byte s−8 is mapped loads the data into that captured byte. In the same cycle it raises clk_wr with clk_idx = s−8 and clk_data = the data, and ram_we stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| live_time | input | 40 | Live clock bytes, byte i in bits 8i+7:8i |
| rom_addr | output | ROM_ADDR_W | Physical ROM address |
| ram_addr | output | RAM_ADDR_W | Physical RAM address |
| ram_we | output | 1 | External RAM write strobe |
| ovr_valid | output | 1 | Block drives read data for this address |
| ovr_data | output | 8 | Read data when ovr_valid is set |
| clk_wr | output | 1 | Write strobe to the live clock |
| clk_idx | output | 3 | Clock byte index for clk_wr |
| clk_data | output | 8 | Data for clk_wr |

## Verification
The assertions check several rules on every cycle:
- The fixed ROM area maps straight through.
- A bank value of 0 yields bank 1.
- A disabling write always leaves the window reading 0xFF.
- RAM writes and clock writes never coincide.
- A snapshot never fires on two cycles in a row.

Other behaviour can only be shown by the bench's scenarios:
- Which captured byte appears for each selector value, and the bits forced to 1 in byte 4.
- That a second set write leaves old snapshot values in place.
- The truncated ROM and RAM addresses for banks that exceed the fitted sizes.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    localparam int CLK_BYTES = 5;
    localparam logic [7:0] CLK_SEL_FIRST = 8'd8;
    localparam logic [7:0] CLK_SEL_LAST  = 8'd12;
    localparam logic [7:0] TOP_BYTE_FILL = 8'h3E;

    typedef enum logic {
        LATCH_LOW,
        LATCH_HIGH
    } latch_st_t;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_OFF,
        WIN_RAM,
        WIN_CLOCK
    } win_mode_t;
endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
    import cbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] addr_top,
    input  logic [7:0] wdata,
    output logic       ram_on,
    output logic [7:0] rom_bank,
    output logic [7:0] ram_sel,
    output logic       snap_go
);
    latch_st_t st_q, st_d;
    logic [7:0] bank_q;

    wire is_en_wr    = wr && (addr_top == 3'b000);
    wire is_rom_wr   = wr && (addr_top == 3'b001);
    wire is_sel_wr   = wr && (addr_top == 3'b010);
    wire is_latch_wr = wr && (addr_top == 3'b011);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_on  <= 1'b0;
            bank_q  <= 8'h00;
            ram_sel <= 8'h00;
        end else begin
            if (is_en_wr)  ram_on  <= (wdata[3:0] == 4'hA);
            if (is_rom_wr) bank_q  <= wdata;
            if (is_sel_wr) ram_sel <= wdata;
        end
    end

    // State register of the capture machine
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LATCH_LOW;
        else        st_q <= st_d;
    end

    // Next state and snapshot output
    always_comb begin
        st_d    = st_q;
        snap_go = 1'b0;
        unique case (st_q)
            LATCH_LOW: begin
                if (is_latch_wr && wdata[0]) begin
                    st_d    = LATCH_HIGH;   // CAPTURE
                    snap_go = 1'b1;
                end
            end
            LATCH_HIGH: begin
                if (is_latch_wr && !wdata[0]) st_d = LATCH_LOW; // REARM
            end
            default: st_d = LATCH_LOW;
        endcase
    end

    assign rom_bank = (bank_q == 8'h00) ? 8'h01 : bank_q;
endmodule

// File: rtl/cbc_clock_latch.sv
module cbc_clock_latch
    import cbc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snap_go,
    input  logic [CLK_BYTES*8-1:0] live_time,
    input  logic                   upd_en,
    input  logic [2:0]             upd_idx,
    input  logic [7:0]             upd_data,
    output logic [CLK_BYTES*8-1:0] held
);
    for (genvar i = 0; i < CLK_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                held[i*8 +: 8] <= 8'h00;
            else if (snap_go)
                held[i*8 +: 8] <= live_time[i*8 +: 8];
            else if (upd_en && (upd_idx == 3'(i)))
                held[i*8 +: 8] <= upd_data;
        end
    end
endmodule

// File: rtl/cbc_window_map.sv
module cbc_window_map
    import cbc_pkg::*;
#(
    parameter int ROM_ADDR_W = 20,
    parameter int RAM_ADDR_W = 15,
    parameter int HAS_RAM    = 1
) (
    input  logic [15:0]            cpu_addr,
    input  logic [7:0]             cpu_wdata,
    input  logic                   cpu_wr,
    input  logic                   ram_on,
    input  logic [7:0]             rom_bank,
    input  logic [7:0]             ram_sel,
    input  logic [CLK_BYTES*8-1:0] held,
    output logic [ROM_ADDR_W-1:0]  rom_addr,
    output logic [RAM_ADDR_W-1:0]  ram_addr,
    output logic                   ram_we,
    output logic                   ovr_valid,
    output logic [7:0]             ovr_data,
    output logic                   clk_wr,
    output logic [2:0]             clk_idx,
    output logic [7:0]             clk_data
);
    localparam bit RAM_FITTED = (HAS_RAM != 0);

    win_mode_t mode;
    logic      in_win, sel_clock;
    logic [7:0] held_byte;

    assign in_win    = (cpu_addr[15:13] == 3'b101);
    assign sel_clock = (ram_sel >= CLK_SEL_FIRST) && (ram_sel <= CLK_SEL_LAST);
    assign clk_idx   = ram_sel[2:0];
    assign clk_data  = cpu_wdata;
    assign held_byte = held[clk_idx*8 +: 8];

    always_comb begin
        if (cpu_addr[14])
            rom_addr = ROM_ADDR_W'({rom_bank, cpu_addr[13:0]});
        else
            rom_addr = ROM_ADDR_W'(cpu_addr[13:0]);
        ram_addr = RAM_ADDR_W'({ram_sel, cpu_addr[12:0]});
    end

    always_comb begin
        if (!in_win)                     mode = WIN_NONE;
        else if (!ram_on || !RAM_FITTED) mode = WIN_OFF;
        else if (sel_clock)              mode = WIN_CLOCK;
        else                             mode = WIN_RAM;
    end

    always_comb begin
        ram_we    = 1'b0;
        clk_wr    = 1'b0;
        ovr_valid = 1'b0;
        ovr_data  = 8'hFF;
        unique case (mode)
            WIN_NONE: ;
            WIN_OFF:  ovr_valid = 1'b1;
            WIN_RAM:  ram_we = cpu_wr;
            WIN_CLOCK: begin
                ovr_valid = 1'b1;
                clk_wr    = cpu_wr;
                ovr_data  = held_byte | ((clk_idx == 3'd4) ? TOP_BYTE_FILL : 8'h00);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_ADDR_W = 20,
    parameter int RAM_ADDR_W = 15,
    parameter int HAS_RAM    = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic [7:0]            cpu_wdata,
    input  logic                  cpu_wr,
    input  logic [39:0]           live_time,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic                  ram_we,
    output logic                  ovr_valid,
    output logic [7:0]            ovr_data,
    output logic                  clk_wr,
    output logic [2:0]            clk_idx,
    output logic [7:0]            clk_data
);
    logic       ram_on, snap_go;
    logic [7:0] rom_bank, ram_sel;
    logic [CLK_BYTES*8-1:0] held;

    cbc_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cpu_wr),
        .addr_top (cpu_addr[15:13]),
        .wdata    (cpu_wdata),
        .ram_on   (ram_on),
        .rom_bank (rom_bank),
        .ram_sel  (ram_sel),
        .snap_go  (snap_go)
    );

    cbc_clock_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_go   (snap_go),
        .live_time (live_time),
        .upd_en    (clk_wr),
        .upd_idx   (clk_idx),
        .upd_data  (clk_data),
        .held      (held)
    );

    cbc_window_map #(
        .ROM_ADDR_W (ROM_ADDR_W),
        .RAM_ADDR_W (RAM_ADDR_W),
        .HAS_RAM    (HAS_RAM)
    ) u_map (
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wr    (cpu_wr),
        .ram_on    (ram_on),
        .rom_bank  (rom_bank),
        .ram_sel   (ram_sel),
        .held      (held),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ovr_valid (ovr_valid),
        .ovr_data  (ovr_data),
        .clk_wr    (clk_wr),
        .clk_idx   (clk_idx),
        .clk_data  (clk_data)
    );
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
    parameter int ROM_ADDR_W = 20
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [15:0]           cpu_addr,
    input logic [7:0]            cpu_wdata,
    input logic                  cpu_wr,
    input logic [ROM_ADDR_W-1:0] rom_addr,
    input logic                  ram_we,
    input logic                  ovr_valid,
    input logic [7:0]            ovr_data,
    input logic                  clk_wr,
    input logic                  snap_go
);
    p_fixed_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr == ROM_ADDR_W'(cpu_addr[13:0])));

    p_bank_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_wdata == 8'h00) |=>
        ((cpu_addr[15:14] != 2'b01) ||
         (rom_addr == ROM_ADDR_W'({2'b01, cpu_addr[13:0]}))));

    p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA) |=>
        ((cpu_addr[15:13] != 3'b101) || (ovr_valid && ovr_data == 8'hFF && !ram_we && !clk_wr)));

    p_write_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, clk_wr}));

    p_ram_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_wr && !ovr_valid));

    p_single_snap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_go |=> !snap_go);
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.ROM_ADDR_W(ROM_ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .rom_addr  (rom_addr),
    .ram_we    (ram_we),
    .ovr_valid (ovr_valid),
    .ovr_data  (ovr_data),
    .clk_wr    (clk_wr),
    .snap_go   (snap_go)
);

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
    localparam int RW = 20;
    localparam int AW = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [39:0] live_time = 40'h0;
    logic [RW-1:0] rom_addr;
    logic [AW-1:0] ram_addr;
    logic ram_we, ovr_valid, clk_wr;
    logic [7:0] ovr_data, clk_data;
    logic [2:0] clk_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef enum int {K_ROM, K_RAM, K_WE, K_OV, K_OD, K_CW, K_CI, K_CD} kind_t;
    typedef struct {
        kind_t       kind;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    cart_bank_ctrl #(.ROM_ADDR_W(RW), .RAM_ADDR_W(AW), .HAS_RAM(1)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .live_time(live_time), .rom_addr(rom_addr),
        .ram_addr(ram_addr), .ram_we(ram_we), .ovr_valid(ovr_valid),
        .ovr_data(ovr_data), .clk_wr(clk_wr), .clk_idx(clk_idx), .clk_data(clk_data)
    );

    function automatic logic [31:0] observe(kind_t k);
        case (k)
            K_ROM:   return 32'(rom_addr);
            K_RAM:   return 32'(ram_addr);
            K_WE:    return 32'(ram_we);
            K_OV:    return 32'(ovr_valid);
            K_OD:    return 32'(ovr_data);
            K_CW:    return 32'(clk_wr);
            K_CI:    return 32'(clk_idx);
            default: return 32'(clk_data);
        endcase
    endfunction

    // Monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            wait (sb.size() > 0);
            begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = observe(it.kind);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%s actual=%0h expected=%0h", it.req, it.kind.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(kind_t k, logic [31:0] e, string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        sb.push_back(it);
        #1;
    endtask

    // Put a bus cycle up after a falling edge; outputs are sampled before the rising edge
    task automatic bus(logic [15:0] a, logic [7:0] d, logic w);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = w;
        #2;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus(a, d, 1'b1);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OV, 1, "R1"); expect_out(K_OD, 8'hFF, "R1");
        bus(16'h4000, 8'h00, 1'b0);
        expect_out(K_ROM, 32'h04000, "R1 R4");
        wr(16'h0000, 8'h0A); wr(16'h4000, 8'h08);
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OD, 8'h00, "R1");
        wr(16'h4000, 8'h0C);
        bus(16'hB000, 8'h00, 1'b0);
        expect_out(K_OD, 8'h3E, "R1 R7");
        wr(16'h0000, 8'h00);

        // R3: fixed area and switchable area
        bus(16'h1234, 8'h00, 1'b0);
        expect_out(K_ROM, 32'h01234, "R3");
        wr(16'h2000, 8'h45);
        bus(16'h4010, 8'h00, 1'b0);
        expect_out(K_ROM, 32'h14010, "R3");
        wr(16'h3FFF, 8'h7F);
        bus(16'h7FFF, 8'h00, 1'b0);
        expect_out(K_ROM, 32'hFFFFF, "R3");
        bus(16'h3FFF, 8'h00, 1'b0);
        expect_out(K_ROM, 32'h03FFF, "R3");
        // R4: bank 0 becomes bank 1
        wr(16'h2100, 8'h00);
        bus(16'h5ABC, 8'h00, 1'b0);
        expect_out(K_ROM, 32'h05ABC, "R4");

        // R6: disabled window
        wr(16'h4000, 8'h03);
        bus(16'hA456, 8'h5A, 1'b1);
        expect_out(K_OV, 1, "R6"); expect_out(K_OD, 8'hFF, "R6");
        expect_out(K_WE, 0, "R6"); expect_out(K_CW, 0, "R6");
        @(negedge clk); cpu_wr = 1'b0;
        bus(16'h8000, 8'h00, 1'b0);
        expect_out(K_OV, 0, "R6");

        // R2: enable with low nibble A, upper nibble ignored
        wr(16'h1000, 8'h3A);
        bus(16'hA456, 8'h5A, 1'b1);
        expect_out(K_OV, 0, "R2 R5"); expect_out(K_WE, 1, "R2 R5");
        expect_out(K_RAM, 32'h6456, "R5");
        @(negedge clk); cpu_wr = 1'b0;
        wr(16'h5FFF, 8'h0D);
        bus(16'hBFFF, 8'h00, 1'b0);
        expect_out(K_RAM, 32'h3FFF, "R5"); expect_out(K_OV, 0, "R5");
        wr(16'h0000, 8'h0B);
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OV, 1, "R2"); expect_out(K_OD, 8'hFF, "R2");
        wr(16'h0000, 8'hAA);

        // R8: snapshot on rising bit 0
        live_time = {8'h55, 8'h21, 8'h3B, 8'h17, 8'h2A};
        wr(16'h6000, 8'h00);
        wr(16'h4000, 8'h08);
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OD, 8'h00, "R8");
        wr(16'h6000, 8'h01);
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OV, 1, "R7"); expect_out(K_OD, 8'h2A, "R8 R7");
        wr(16'h4000, 8'h0C);
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OD, 8'h7F, "R7");
        wr(16'h4000, 8'h0A);
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OD, 8'h3B, "R7");
        live_time = {8'h80, 8'h11, 8'h22, 8'h33, 8'h44};
        wr(16'h7000, 8'h01);
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OD, 8'h3B, "R8");
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h03);
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OD, 8'h22, "R8");
        wr(16'h4000, 8'h0C);
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OD, 8'hBE, "R7 R8");

        // R9: write to a mapped clock byte
        wr(16'h4000, 8'h0A);
        bus(16'hA123, 8'h99, 1'b1);
        expect_out(K_CW, 1, "R9"); expect_out(K_CI, 2, "R9");
        expect_out(K_CD, 8'h99, "R9"); expect_out(K_WE, 0, "R9");
        @(negedge clk); cpu_wr = 1'b0;
        bus(16'hA000, 8'h00, 1'b0);
        expect_out(K_OD, 8'h99, "R9");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            repeat (20000) @(posedge clk);
        join_any
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
        end
        #5;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule